// File: doc/BRIEF.md
# Banked Calibration Command Decoder

This block sits behind a byte-wide command port. It tracks a 3-bit instruction bank and decodes the bytes that work on a 6-bit calibration offset. The offset is split into a 2-bit upper field (bits 5..4) and a 4-bit lower field (bits 3..0).

While the bank is 4, the host can do four things:
- stage either field;
- choose which field the next memory operation acts on;
- start a timed program operation, which copies the chosen staged field into a nonvolatile store;
- start a timed read operation, which copies the chosen stored field into the working calibration register that drives the analog side.

A soft reset command, accepted only in bank 0, clears the working register and the bank but leaves the store untouched. Power-on reset clears everything, including the store.

Commands arrive on a valid/ready stream. The block never applies back-pressure: `cmd_ready` stays high, and every byte with `cmd_valid` high is consumed on that edge. A byte that arrives at a bad moment, such as a wrong bank, an active operation or a missing staged field, is consumed and then discarded. It is never held off. `busy` shows that a timed operation is running. `mem_mode` reports the memory mode: 00 idle, 01 program, 10 read.

Top module: `cal_cmd_decoder`

## Requirements
- R1: After `rst_n` is low, `cal_word` is 0, `busy` is 0, `mem_mode` is 00, the bank is 0 and the store holds 0.
- R2: A byte 0xF0..0xF7 sets the bank to its low 3 bits. In any bank other than 4, the bytes 0x6X, 0x7X, 0xA0, 0xA1, 0x50, 0x52 and 0x56 have no effect.
- R3: In bank 4, byte 0x7X stages the upper field from X[1:0], and byte 0x6X stages the lower field from X[3:0]. Each load marks that field as written.
- R4: In bank 4, byte 0xA0 selects the lower field (select 00) and byte 0xA1 selects the upper field (select 01). Select is 00 after any reset.
- R5: Byte 0x52 with both fields written starts a program operation. `mem_mode` becomes 01, `busy` is high for exactly PROG_CYCLES cycles, and the selected store field then takes the staged value. `cal_word` is unchanged.
- R6: Byte 0x52 is ignored unless both fields have been staged since the last reset. When ignored, `busy` and `mem_mode` do not change.
- R7: Byte 0x50 starts a read operation. `busy` is high for exactly READ_CYCLES cycles, and then the selected field of `cal_word` takes the stored field while the other field is kept.
- R8: While `busy` is high, all bank-4 commands are ignored, including 0x50, 0x52 and 0x56. `mem_mode` stays unchanged and the operation runs to completion.
- R9: Byte 0x56 sets `mem_mode` to 00. `mem_mode` keeps 01 or 10 after an operation completes, until 0x56 or a reset.
- R10: Byte 0x91 in bank 0 does the following: clears `cal_word`, the bank, the select and the written marks; aborts any running operation; sets `mem_mode` to 00; and keeps the store. In other banks 0x91 does nothing.
- R11: Bytes that are not listed here have no effect.
- R12: `cmd_ready` is always high. A byte is consumed on every edge where `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Always high; the block never stalls |
| cmd_data | input | 8 | Command byte |
| cal_word | output | 6 | Working calibration register |
| busy | output | 1 | Program or read operation in progress |
| mem_mode | output | 2 | Memory mode: 00 idle, 01 program, 10 read |

## Verification
The assertions assume that `cmd_valid` and `cmd_data` are known after reset and that `rst_n` is a clean synchronous level. The soft reset may arrive at any time, including in the middle of an operation. The stimulus changes inputs only at falling edges and holds each byte for one edge. It deliberately issues commands during busy windows, in the wrong bank and before both fields are staged, so that the gating paths the assertions cover are actually exercised.

// File: rtl/cal_cmd_pkg.sv
package cal_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_PROG = 2'b01,
    MODE_READ = 2'b10
  } nvm_mode_e;

  localparam int BANK_W = 3;
  localparam logic [BANK_W-1:0] CAL_BANK  = 3'd4;
  localparam logic [BANK_W-1:0] BASE_BANK = 3'd0;

  typedef struct packed {
    logic              set_bank;
    logic [BANK_W-1:0] bank_val;
    logic              load_hi;
    logic              load_lo;
    logic              sel_lo;
    logic              sel_hi;
    logic              prog;
    logic              read;
    logic              idle;
    logic              soft_rst;
  } cmd_op_t;

endpackage

// File: rtl/cal_cmd_parse.sv
module cal_cmd_parse
  import cal_cmd_pkg::*;
(
  input  logic              cmd_fire,
  input  logic [7:0]        cmd_byte,
  input  logic [BANK_W-1:0] cur_bank,
  input  logic              busy,
  output cmd_op_t           op
);

  logic in_cal;
  logic gate;

  always_comb begin
    op     = '0;
    in_cal = (cur_bank == CAL_BANK);
    gate   = in_cal && !busy;
    if (cmd_fire) begin
      if (cmd_byte[7:3] == 5'b11110) begin
        op.set_bank = 1'b1;
        op.bank_val = cmd_byte[BANK_W-1:0];
      end else if (cmd_byte == 8'h91) begin
        op.soft_rst = (cur_bank == BASE_BANK);
      end else if (gate) begin
        case (cmd_byte[7:4])
          4'h7: op.load_hi = 1'b1;
          4'h6: op.load_lo = 1'b1;
          4'hA: begin
            op.sel_lo = (cmd_byte[3:0] == 4'h0);
            op.sel_hi = (cmd_byte[3:0] == 4'h1);
          end
          4'h5: begin
            op.read = (cmd_byte[3:0] == 4'h0);
            op.prog = (cmd_byte[3:0] == 4'h2);
            op.idle = (cmd_byte[3:0] == 4'h6);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cal_op_timer.sv
module cal_op_timer #(
  parameter int PROG_CYCLES = 500_001,
  parameter int READ_CYCLES = 1_251
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_read,
  input  logic abort,
  output logic busy,
  output logic prog_done,
  output logic read_done
);

  localparam int MAX_CYC = (PROG_CYCLES > READ_CYCLES) ? PROG_CYCLES : READ_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             kind_read_q;
  logic             last;

  assign busy      = (cnt_q != '0);
  assign last      = (cnt_q == CNT_W'(1));
  assign prog_done = last && !kind_read_q && !abort;
  assign read_done = last &&  kind_read_q && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      kind_read_q <= 1'b0;
    end else if (abort) begin
      cnt_q       <= '0;
    end else if (start_prog) begin
      cnt_q       <= CNT_W'(PROG_CYCLES);
      kind_read_q <= 1'b0;
    end else if (start_read) begin
      cnt_q       <= CNT_W'(READ_CYCLES);
      kind_read_q <= 1'b1;
    end else if (busy) begin
      cnt_q       <= cnt_q - CNT_W'(1);
    end
  end

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done || read_done) |=> !busy) else $error("done left busy");  // R5
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_prog || start_read) && !abort) |=> busy) else $error("start without busy");  // R7
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy) else $error("abort ignored");  // R10

endmodule

// File: rtl/cal_nv_store.sv
module cal_nv_store #(
  parameter int HI_W = 2,
  parameter int LO_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_hi,
  input  logic                 load_lo,
  input  logic [LO_W-1:0]      load_data,
  input  logic                 clr_seen,
  input  logic                 commit,
  input  logic                 commit_hi,
  output logic [HI_W+LO_W-1:0] stored,
  output logic                 staged_ready
);

  localparam int CAL_W = HI_W + LO_W;

  logic [HI_W-1:0]  stage_hi_q;
  logic [LO_W-1:0]  stage_lo_q;
  logic             seen_hi_q;
  logic             seen_lo_q;
  logic [CAL_W-1:0] store_q;

  assign stored       = store_q;
  assign staged_ready = seen_hi_q && seen_lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_hi_q <= '0;
      stage_lo_q <= '0;
      seen_hi_q  <= 1'b0;
      seen_lo_q  <= 1'b0;
    end else if (clr_seen) begin
      seen_hi_q  <= 1'b0;
      seen_lo_q  <= 1'b0;
    end else begin
      if (load_hi) begin
        stage_hi_q <= load_data[HI_W-1:0];
        seen_hi_q  <= 1'b1;
      end
      if (load_lo) begin
        stage_lo_q <= load_data;
        seen_lo_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (commit) begin
      if (commit_hi) store_q[CAL_W-1:LO_W] <= stage_hi_q;
      else           store_q[LO_W-1:0]     <= stage_lo_q;
    end
  end

  AST_STORE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(store_q)) else $error("store moved");  // R10
  AST_COMMIT_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> staged_ready) else $error("commit unstaged");  // R6

endmodule

// File: rtl/cal_cmd_decoder.sv
module cal_cmd_decoder
  import cal_cmd_pkg::*;
#(
  parameter int PROG_CYCLES = 500_001,
  parameter int READ_CYCLES = 1_251,
  parameter int HI_W        = 2,
  parameter int LO_W        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [7:0]           cmd_data,
  output logic [HI_W+LO_W-1:0] cal_word,
  output logic                 busy,
  output logic [1:0]           mem_mode
);

  localparam int CAL_W = HI_W + LO_W;

  cmd_op_t           op;
  logic [BANK_W-1:0] bank_q;
  logic [1:0]        sel_q;
  nvm_mode_e         mode_q;
  logic [CAL_W-1:0]  cal_q;
  logic [CAL_W-1:0]  stored;
  logic              staged_ready;
  logic              start_prog;
  logic              start_read;
  logic              prog_done;
  logic              read_done;
  logic              sel_hi;
  logic              cmd_fire;

  assign cmd_ready  = 1'b1;
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign start_prog = op.prog && staged_ready;
  assign start_read = op.read;
  assign sel_hi     = (sel_q == 2'b01);

  cal_cmd_parse u_parse (
    .cmd_fire (cmd_fire),
    .cmd_byte (cmd_data),
    .cur_bank (bank_q),
    .busy     (busy),
    .op       (op)
  );

  cal_op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .READ_CYCLES (READ_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_prog (start_prog),
    .start_read (start_read),
    .abort      (op.soft_rst),
    .busy       (busy),
    .prog_done  (prog_done),
    .read_done  (read_done)
  );

  cal_nv_store #(
    .HI_W (HI_W),
    .LO_W (LO_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_hi      (op.load_hi),
    .load_lo      (op.load_lo),
    .load_data    (cmd_data[LO_W-1:0]),
    .clr_seen     (op.soft_rst),
    .commit       (prog_done),
    .commit_hi    (sel_hi),
    .stored       (stored),
    .staged_ready (staged_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || op.soft_rst) begin
      bank_q <= BASE_BANK;
      sel_q  <= 2'b00;
      mode_q <= MODE_IDLE;
    end else begin
      if (op.set_bank) bank_q <= op.bank_val;
      if (op.sel_lo)   sel_q  <= 2'b00;
      if (op.sel_hi)   sel_q  <= 2'b01;
      if (start_prog)       mode_q <= MODE_PROG;
      else if (start_read)  mode_q <= MODE_READ;
      else if (op.idle)     mode_q <= MODE_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || op.soft_rst) begin
      cal_q <= '0;
    end else if (read_done) begin
      if (sel_hi) cal_q[CAL_W-1:LO_W] <= stored[CAL_W-1:LO_W];
      else        cal_q[LO_W-1:0]     <= stored[LO_W-1:0];
    end
  end

  assign cal_word = cal_q;
  assign mem_mode = mode_q;

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_read) |-> !busy) else $error("start while busy");  // R8
  AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    op.soft_rst |=> (cal_word == '0 && !busy && mem_mode == 2'b00)) else $error("soft reset");  // R10
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_done && !op.soft_rst) |=> $stable(cal_word)) else $error("word moved");  // R7
  AST_MODE_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op.soft_rst) |=> $stable(mem_mode)) else $error("mode moved while busy");  // R8

endmodule

// File: tb/cal_cmd_decoder_tb_top.sv
module cal_cmd_decoder_tb_top;

  localparam int TB_PROG = 40;
  localparam int TB_READ = 7;
  localparam int NV      = 19;
  // entry = {command byte, check flag, pad, expected cal_word}
  localparam logic [15:0] VEC [NV] = '{
    16'hF400, 16'h7100, 16'h6E00, 16'hA100, 16'h5200, 16'h5600, 16'h5680,
    16'hA000, 16'h5200, 16'h5600, 16'hF000, 16'h9180, 16'hF400, 16'hA100,
    16'h5000, 16'h5690, 16'hA000, 16'h5000, 16'h569E
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = 8'h00;
  logic [5:0] cal_word;
  logic       busy;
  logic [1:0] mem_mode;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cal_cmd_decoder #(
    .PROG_CYCLES (TB_PROG),
    .READ_CYCLES (TB_READ)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .cal_word  (cal_word),
    .busy      (busy),
    .mem_mode  (mem_mode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 cal_word", cal_word, 0);
    check("R1 busy", busy, 0);
    check("R1 mode", mem_mode, 0);
    check("R12 ready", cmd_ready, 1);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][15:8]);
      if (VEC[v][15:8] == 8'h52 || VEC[v][15:8] == 8'h50) wait_idle();
      if (VEC[v][7]) check("R3/R4/R5/R7 vector", cal_word, int'(VEC[v][5:0]));
    end

    // R6: program refused with only the lower field staged
    send(8'h65);
    send(8'h52);
    check("R6 busy", busy, 0);
    check("R6 mode", mem_mode, 0);
    send(8'h50); wait_idle(); send(8'h56);
    check("R6 store kept", cal_word, 6'h1E);

    // R2: wrong bank ignores calibration commands
    send(8'hF5);
    send(8'h50);
    check("R2 busy", busy, 0);
    check("R2 mode", mem_mode, 0);

    // R5, R9: program upper field, exact busy length
    send(8'hF4); send(8'h73); send(8'hA1); send(8'h52);
    busy_len(n);
    check("R5 prog length", n, TB_PROG);
    check("R9 mode holds prog", mem_mode, 1);
    check("R5 cal untouched", cal_word, 6'h1E);

    // R8: commands while busy ignored
    send(8'h52);
    send(8'h56);
    check("R8 idle ignored", mem_mode, 1);
    send(8'h50);
    check("R8 read ignored", mem_mode, 1);
    check("R8 still busy", busy, 1);
    wait_idle();
    send(8'h56);
    check("R9 idle", mem_mode, 0);

    // R7: read upper field, exact busy length
    send(8'h50);
    check("R9 read mode", mem_mode, 2);
    busy_len(n);
    check("R7 read length", n, TB_READ);
    check("R7 cal", cal_word, 6'h3E);
    send(8'h56);

    // R10: soft reset only in bank 0, store kept
    send(8'h91);
    check("R10 bank4 ignored", cal_word, 6'h3E);
    send(8'hF0); send(8'h91);
    check("R10 cleared", cal_word, 0);
    check("R10 mode", mem_mode, 0);
    send(8'hF4); send(8'hA1); send(8'h50); wait_idle();
    send(8'hA0); send(8'h50); wait_idle(); send(8'h56);
    check("R10 store kept", cal_word, 6'h3E);

    // R10: soft reset aborts a running read
    send(8'hF0); send(8'h91);
    send(8'hF4); send(8'hA0); send(8'h50);
    send(8'hF0); send(8'h91);
    check("R10 abort busy", busy, 0);
    repeat (20) @(negedge clk);
    check("R10 abort cal", cal_word, 0);

    // R11: unlisted bytes inert
    send(8'hF4); send(8'hA1); send(8'h50); wait_idle(); send(8'h56);
    send(8'h33); send(8'h8F); send(8'h5F);
    check("R11 no effect", cal_word, 6'h30);
    check("R11 mode", mem_mode, 0);

    // R3, R4: stage both, program lower only
    send(8'h72); send(8'h69); send(8'hA0); send(8'h52); wait_idle(); send(8'h56);
    send(8'h50); wait_idle(); send(8'h56);
    check("R3 lower programmed", cal_word, 6'h39);
    send(8'hA1); send(8'h50); wait_idle();
    check("R4 upper untouched", cal_word, 6'h39);
    check("R12 ready", cmd_ready, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule